// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is a small register-bus master that takes a PLL through a safe reconfiguration whenever it is asked to. On a start request it captures a new multiplier word. It reads the PLL control register and writes it back with the PLL powered down and its bypass, direct and output-enable bits cleared. It then loads the multiplier register and a fixed divider word that sets both pre- and post-division to one. Next it powers the PLL up and polls the lock flag. Once lock is seen it turns the PLL output clock on.

The lock poll is bounded by a count of status reads given on an input. If lock never shows within that count, the sequence stops with the output clock still disabled and reports an error. A one-cycle done pulse marks the end of every run, whether it succeeded or failed. All register addresses are formed from a base address input plus a fixed offset per register.

Top module: `pll_reseq`

## Requirements
- R1: While reset is held and after it is released, bus_valid, done and err are low until a start is accepted, and bus_valid is low in any cycle where done is high.
- R2: After an accepted start, the first bus request is a read of the control register at pll_base+0x4. The multiplier word present on mult_word in the start cycle is captured.
- R3: The second request writes pll_base+0x4 with the value read, bit 0 (power-down) set and bits 1 to 4 (bypass, input-direct, output-direct, clock enable) cleared, and every other bit unchanged.
- R4: The third request writes the captured multiplier word to pll_base+0x8. The fourth writes the constant 0x00302062 to pll_base+0xC.
- R5: The fifth request writes pll_base+0x4 with the power-down word from R3, with bit 0 cleared.
- R6: The block then reads pll_base+0x0 repeatedly; bit 0 of the read data is the lock flag and the other bits are ignored. On the first read with lock set, it writes pll_base+0x4 with the R5 word plus bit 4 set, then ends with err low.
- R7: At most max(lock_limit,1) status reads are made. If the last one allowed shows no lock, no further request follows and the run ends with err high. Lock on exactly the last allowed read counts as success.
- R8: A request keeps bus_valid, bus_write, bus_addr and bus_wdata stable until bus_ready is seen, and the next request comes only after that.
- R9: A start raised while a run is in progress is ignored: it changes neither the captured multiplier nor the number of runs.
- R10: done is high for exactly one cycle per run. err, once raised, stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a reprogramming run (taken only when idle) |
| mult_word | input | DW | Multiplier register value to load |
| lock_limit | input | TW | Maximum number of status reads (0 treated as 1) |
| pll_base | input | AW | Base address of the PLL register group |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Request address |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Request accepted; read data valid in the same cycle |
| bus_rdata | input | DW | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Lock timeout flag |

## Verification
The lock flag and the poll limit can be reached in the same status read: the read that first shows lock may also be the last read the limit allows. The bench models the PLL so that lock appears after a chosen number of reads. It sets that number equal to lock_limit, and also uses lock_limit of zero with lock on the first read. It judges the outcome by a clock-enable write and err low, while one read more than the limit must produce err and no enable write. A second overlap, a start raised in the middle of a run, is provoked with a different multiplier word. It is judged by the multiplier register contents and by a single done pulse.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_WR_PD,
        ST_WR_MUL,
        ST_WR_DIV,
        ST_WR_PU,
        ST_POLL,
        ST_WR_EN
    } seq_state_e;

    // register offsets relative to the PLL base
    localparam int OFS_STAT = 0;
    localparam int OFS_CTRL = 4;
    localparam int OFS_MULT = 8;
    localparam int OFS_DIV  = 12;

    // control register bit positions
    localparam int BIT_PWRDN  = 0;
    localparam int BIT_BYPASS = 1;
    localparam int BIT_DIR_IN = 2;
    localparam int BIT_DIR_OUT = 3;
    localparam int BIT_CLK_EN = 4;

    // status register bit position
    localparam int BIT_LOCK = 0;

endpackage

// File: rtl/pll_reseq_pollcnt.sv
module pll_reseq_pollcnt #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          last
);
    localparam int CW = TW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] eff_limit;

    always_comb begin
        eff_limit = (limit == '0) ? CW'(1) : {1'b0, limit};
        last      = ((cnt_q + CW'(1)) >= eff_limit);
        cnt_d     = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pll_reseq_ctlword.sv
module pll_reseq_ctlword
    import pll_reseq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] ctrl_rd,
    output logic [DW-1:0] pd_word,
    output logic [DW-1:0] pu_word,
    output logic [DW-1:0] en_word
);
    localparam logic [DW-1:0] CLR_MASK = (DW'(1) << BIT_BYPASS) | (DW'(1) << BIT_DIR_IN)
                                       | (DW'(1) << BIT_DIR_OUT) | (DW'(1) << BIT_CLK_EN);
    localparam logic [DW-1:0] PD_MASK  = DW'(1) << BIT_PWRDN;
    localparam logic [DW-1:0] EN_MASK  = DW'(1) << BIT_CLK_EN;

    always_comb begin
        pd_word = (ctrl_rd & ~CLR_MASK) | PD_MASK;
        pu_word = pd_word & ~PD_MASK;
        en_word = pu_word | EN_MASK;
    end

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
    import pll_reseq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter int          TW       = 16,
    parameter logic [31:0] DIV_WORD = 32'h0030_2062
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] mult_word,
    input  logic [TW-1:0] lock_limit,
    input  logic [AW-1:0] pll_base,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          done,
    output logic          err
);
    localparam logic [DW-1:0] DIV_VAL = DW'(DIV_WORD);

    typedef struct packed {
        seq_state_e    st;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mult;
        logic          done;
        logic          err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          cnt_clear, cnt_tick, cnt_last;
    logic [DW-1:0] pd_word, pu_word, en_word;

    pll_reseq_ctlword #(.DW(DW)) u_words (
        .ctrl_rd (r_q.ctrl),
        .pd_word (pd_word),
        .pu_word (pu_word),
        .en_word (en_word)
    );

    pll_reseq_pollcnt #(.TW(TW)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (cnt_tick),
        .limit (lock_limit),
        .last  (cnt_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cnt_clear = 1'b0;
        cnt_tick  = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = pll_base;
        bus_wdata = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.mult  = mult_word;
                    r_d.err   = 1'b0;
                    r_d.st    = ST_RD_CTRL;
                    cnt_clear = 1'b1;
                end
            end
            ST_RD_CTRL: begin
                bus_valid = 1'b1;
                bus_addr  = pll_base + AW'(OFS_CTRL);
                if (bus_ready) begin
                    r_d.ctrl = bus_rdata;
                    r_d.st   = ST_WR_PD;
                end
            end
            ST_WR_PD: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = pll_base + AW'(OFS_CTRL);
                bus_wdata = pd_word;
                if (bus_ready) r_d.st = ST_WR_MUL;
            end
            ST_WR_MUL: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = pll_base + AW'(OFS_MULT);
                bus_wdata = r_q.mult;
                if (bus_ready) r_d.st = ST_WR_DIV;
            end
            ST_WR_DIV: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = pll_base + AW'(OFS_DIV);
                bus_wdata = DIV_VAL;
                if (bus_ready) r_d.st = ST_WR_PU;
            end
            ST_WR_PU: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = pll_base + AW'(OFS_CTRL);
                bus_wdata = pu_word;
                if (bus_ready) r_d.st = ST_POLL;
            end
            ST_POLL: begin
                bus_valid = 1'b1;
                bus_addr  = pll_base + AW'(OFS_STAT);
                if (bus_ready) begin
                    if (bus_rdata[BIT_LOCK]) begin
                        r_d.st = ST_WR_EN;
                    end else if (cnt_last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        cnt_tick = 1'b1;
                    end
                end
            end
            ST_WR_EN: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = pll_base + AW'(OFS_CTRL);
                bus_wdata = en_word;
                if (bus_ready) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ctrl <= '0;
            r_q.mult <= '0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign err  = r_q.err;

endmodule

// File: rtl/pll_reseq_checker.sv
module pll_reseq_checker
    import pll_reseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [AW-1:0] pll_base,
    input logic          done,
    input logic          err
);
    // R8: an unaccepted request is held unchanged
    a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                   && $stable(bus_write) && $stable(bus_wdata));

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: err only rises together with done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R1: no request is outstanding when a run ends
    a_r1_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid);

    // R3: a power-down control write never carries bypass, direct or enable bits
    a_r3_pd_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && (bus_addr == pll_base + AW'(OFS_CTRL))
        && bus_wdata[BIT_PWRDN] |-> (bus_wdata[BIT_CLK_EN:BIT_BYPASS] == '0));

    // R6: the clock enable is only written with the PLL powered and not bypassed
    a_r6_en_powered: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && (bus_addr == pll_base + AW'(OFS_CTRL))
        && bus_wdata[BIT_CLK_EN] |-> (bus_wdata[BIT_DIR_OUT:BIT_PWRDN] == '0));

endmodule

bind pll_reseq pll_reseq_checker #(.AW(AW), .DW(DW)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pll_base  (pll_base),
    .done      (done),
    .err       (err)
);

// File: tb/pll_reseq_bench.sv
`timescale 1ns/1ps
module pll_reseq_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 16;
    localparam int LOGN = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] mult_word = '0;
    logic [TW-1:0] lock_limit = '0;
    logic [AW-1:0] pll_base = 16'h0400;
    logic          bus_valid, bus_write, done, err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    pll_reseq #(.AW(AW), .DW(DW), .TW(TW)) u_pll_reseq (
        .clk(clk), .rst_n(rst_n), .start(start), .mult_word(mult_word),
        .lock_limit(lock_limit), .pll_base(pll_base),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .done(done), .err(err)
    );

    int total = 0;
    int bad = 0;

    // PLL register model and transaction log
    logic [DW-1:0] m_ctrl, m_mult, m_div;
    int            stat_reads;
    int            lock_after;
    int            log_n;
    logic [AW-1:0] log_addr [LOGN];
    logic          log_wr   [LOGN];
    logic [DW-1:0] log_data [LOGN];
    int            done_cnt = 0;
    logic          prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus responder: random wait, one-cycle ready
    initial begin
        int waitc;
        waitc = -1;
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0;
                waitc = -1;
            end else if (bus_valid) begin
                if (waitc < 0) waitc = int'($urandom % 3);
                if (waitc == 0) begin
                    if (log_n < LOGN) begin
                        log_addr[log_n] = bus_addr;
                        log_wr[log_n]   = bus_write;
                        log_data[log_n] = bus_wdata;
                    end
                    log_n++;
                    if (bus_write) begin
                        if (bus_addr == pll_base + 16'h4) m_ctrl = bus_wdata;
                        if (bus_addr == pll_base + 16'h8) m_mult = bus_wdata;
                        if (bus_addr == pll_base + 16'hC) m_div  = bus_wdata;
                        bus_rdata = $urandom;
                    end else if (bus_addr == pll_base + 16'h4) begin
                        bus_rdata = m_ctrl;
                    end else begin
                        stat_reads++;
                        bus_rdata = {$urandom, 1'b0} | DW'(stat_reads >= lock_after);
                    end
                    bus_ready = 1'b1;
                end else begin
                    waitc--;
                end
            end
        end
    end

    // done monitor (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (done && prev_done) chk(1'b0, "R10 done longer than one cycle", 32'd1, 32'd0);
            prev_done = done;
        end
    end

    task automatic run_case(input logic [DW-1:0] init, input logic [DW-1:0] mult,
                            input int lk_after, input int limit, input bit busy_start);
        int d0, t, l_eff, exp_reads, exp_n;
        bit ok_run;
        logic [DW-1:0] pd, pu;
        m_ctrl = init; m_mult = $urandom; m_div = $urandom;
        log_n = 0; stat_reads = 0; lock_after = lk_after;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; mult_word = mult; lock_limit = TW'(limit);
        @(negedge clk);
        start = 1'b0; mult_word = $urandom;
        if (busy_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; mult_word = ~mult;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        l_eff = (limit == 0) ? 1 : limit;
        ok_run = (lk_after <= l_eff);
        exp_reads = ok_run ? lk_after : l_eff;
        exp_n = 5 + exp_reads + (ok_run ? 1 : 0);
        pd = (init & ~32'h1E) | 32'h1;
        pu = pd & ~32'h1;
        chk(done_cnt == d0 + 1, "R10 one done per run (R9 busy start ignored)", done_cnt, d0 + 1);
        chk(log_n == exp_n, "R7 request count", log_n, exp_n);
        chk(stat_reads == exp_reads, "R7 status reads", stat_reads, exp_reads);
        chk(err == !ok_run, "R7 err outcome (R6 err low on lock)", {31'b0, err}, {31'b0, !ok_run});
        chk(bus_valid == 1'b0, "R7 no request after end", {31'b0, bus_valid}, 32'd0);
        if (log_n == exp_n) begin
            chk(!log_wr[0] && log_addr[0] == pll_base + 16'h4, "R2 first read of control",
                {16'b0, log_addr[0]}, {16'b0, pll_base + 16'h4});
            chk(log_wr[1] && log_addr[1] == pll_base + 16'h4 && log_data[1] == pd,
                "R3 power-down write", log_data[1], pd);
            chk(log_wr[2] && log_addr[2] == pll_base + 16'h8 && log_data[2] == mult,
                "R4 multiplier write (R9 start mid-run ignored)", log_data[2], mult);
            chk(log_wr[3] && log_addr[3] == pll_base + 16'hC && log_data[3] == 32'h0030_2062,
                "R4 divider write", log_data[3], 32'h0030_2062);
            chk(log_wr[4] && log_addr[4] == pll_base + 16'h4 && log_data[4] == pu,
                "R5 power-up write", log_data[4], pu);
            for (int i = 5; i < 5 + exp_reads; i++)
                chk(!log_wr[i] && log_addr[i] == pll_base, "R6 status poll address",
                    {16'b0, log_addr[i]}, {16'b0, pll_base});
            if (ok_run)
                chk(log_wr[exp_n-1] && log_addr[exp_n-1] == pll_base + 16'h4
                    && log_data[exp_n-1] == (pu | 32'h10), "R6 clock enable write",
                    log_data[exp_n-1], pu | 32'h10);
        end
        chk(m_ctrl[4] == ok_run, "R7 clock enable state after run", {31'b0, m_ctrl[4]},
            {31'b0, ok_run});
        if (!ok_run) begin
            repeat (5) @(negedge clk);
            chk(err == 1'b1, "R10 err held until next start", {31'b0, err}, 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        log_n = 0; stat_reads = 0; lock_after = 1;
        m_ctrl = '0; m_mult = '0; m_div = '0;
        repeat (3) @(negedge clk);
        chk(!bus_valid && !done && !err, "R1 outputs in reset",
            {29'b0, bus_valid, done, err}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_valid && !done && !err, "R1 idle after reset",
            {29'b0, bus_valid, done, err}, 32'd0);
        // directed corners
        run_case(32'hFFFF_FFFF, 32'h0001_8003, 1, 4, 1'b0);   // all control bits set, lock at once
        run_case(32'h0000_0000, 32'h1234_5678, 3, 3, 1'b0);   // lock on last allowed read
        run_case(32'hA5A5_A5BE, 32'h0BAD_CAFE, 4, 3, 1'b0);   // one read past the limit
        run_case(32'h0000_001F, 32'h0000_0001, 1, 0, 1'b0);   // limit zero, lock first read
        run_case(32'h0000_0010, 32'h0000_0002, 2, 0, 1'b0);   // limit zero, timeout
        run_case(32'h5A5A_5A5A, 32'hCAFE_0001, 6, 8, 1'b1);   // start during run
        // random mix
        for (int k = 0; k < 24; k++) begin
            int la, lim;
            la  = 1 + int'($urandom % 8);
            lim = int'($urandom % 9);
            run_case($urandom, $urandom, la, lim, ($urandom % 4) == 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule